// File: doc/BRIEF.md
# Guarded Peripheral Register Bank

This block is a small bank of control and interrupt registers sitting on a single-cycle register bus. The bus carries a write strobe, a read strobe, a word address, write data, and a tag that marks the access as coming from an external debug probe. Two general configuration words and an interrupt enable mask can each be locked by a lock input driven by an outside access controller. A CPU write to a locked register is dropped, and the bank answers with a one-cycle error pulse.

Locking has three exemptions:
- The interrupt flag register is never locked.
- All locks are lifted while the CPU reports that it is halted for debugging.
- Writes tagged as debugger-sourced always go through.

A set of status lines from neighbouring sub-blocks is synchronised and readable as a status word. A rising edge on a status line latches a flag. Writing a one to a flag bit clears it. Flags qualified by the enable mask drive an interrupt output, and the same qualified condition drives a wake request while the system is in standby.

Top module: `wpr_regbank`

## Requirements
- R1: After reset, every register reads zero, and `bus_err`, `irq`, `wake` and `bus_rdata` are low.
- R2: The register map is: address 0 is configuration word A, 1 is configuration word B, 2 is the interrupt enable mask, 3 is the interrupt flags, and 4 is the status word. An unlocked write updates the addressed register. A read strobe loads `bus_rdata` at the clock edge that samples it. Narrow registers are zero-extended.
- R3: Lock bit 0 guards address 0, bit 1 guards address 1, and bit 2 guards address 2. A non-debugger write to a locked register while the CPU is not halted leaves the register unchanged. `bus_err` is then high for exactly the one cycle after that write.
- R4: Writes to the flag register (address 3) take effect whatever the lock inputs are, and never raise `bus_err`.
- R5: While `cpu_halted` is high, no lock blocks a write, and no error is raised.
- R6: A write with `bus_src_dbg` high is never blocked by a lock, and raises no error.
- R7: The status word reads the status lines through a one-stage synchroniser.
- R8: A flag bit sets on a rising edge of its synchronised status line. A line that stays high does not set the flag again after it is cleared.
- R9: Writing one to a flag bit clears it, and writing zero leaves it as it is. If a set and a clear hit the same bit in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some flag bit and its enable bit are both set.
- R11: `wake` equals `irq` while `standby` is high, and is low otherwise.
- R12: A write to the status word or to an unmapped address changes no register and raises no error. A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_src_dbg | input | 1 | Access comes from an external debugger |
| cpu_halted | input | 1 | CPU halted for debugging, lifts all locks |
| wp_lock | input | 3 | Per-register lock inputs |
| standby | input | 1 | System is in standby |
| stat_in | input | NSTAT | Status lines from sub-blocks |
| bus_rdata | output | DW | Registered read data |
| bus_err | output | 1 | One-cycle error for a blocked write |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request in standby |

## Verification
The bench writes to each guarded register with its lock set and checks the exemptions one at a time:
- debug halt;
- the debugger-sourced tag;
- the flag register.

A design that ignored an exemption would raise `bus_err` and lose the data. A design that ignored the lock would accept the write.

The bench holds a status line high across a clear, to catch a level-triggered flag that sets again at once. It lines up a rising edge with a write-one-to-clear in the same cycle; a design in which the clear wins would lose that event.

It toggles `standby` with a pending interrupt, and writes to the read-only and unmapped addresses. A loose decoder would corrupt a register or raise a false error.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int unsigned NLOCK    = 3;
  localparam int unsigned ADR_CFGA = 0;
  localparam int unsigned ADR_CFGB = 1;
  localparam int unsigned ADR_IEN  = 2;
  localparam int unsigned ADR_IFLG = 3;
  localparam int unsigned ADR_STAT = 4;
endpackage

// File: rtl/wpr_guard.sv
module wpr_guard
  import wpr_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [NLOCK-1:0] lock,
  input  logic             halted,
  input  logic             dbg,
  output logic [NLOCK-1:0] we_lk,
  output logic             we_flg,
  output logic             blocked
);
  logic bypass;

  always_comb begin
    bypass  = halted | dbg;
    we_lk   = '0;
    blocked = 1'b0;
    for (int i = 0; i < NLOCK; i++) begin
      if (wr && (addr == AW'(i))) begin
        if (lock[i] && !bypass) blocked  = 1'b1;
        else                    we_lk[i] = 1'b1;
      end
    end
    we_flg = wr && (addr == AW'(ADR_IFLG));
  end
endmodule

// File: rtl/wpr_flags.sv
module wpr_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_in,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ien,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] stat_prev;
  logic [N-1:0] rise;
  logic [N-1:0] clr;
  logic [N-1:0] flags_d;

  always_comb begin
    rise    = stat_q & ~stat_prev;
    clr     = clr_we ? clr_mask : '0;
    flags_d = (flags & ~clr) | rise;
    irq     = |(flags & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      stat_prev <= '0;
      flags     <= '0;
    end else begin
      stat_q    <= stat_in;
      stat_prev <= stat_q;
      flags     <= flags_d;
    end
  end

  // R9: a set pulse always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((flags & $past(rise)) == $past(rise)));

  // R8: a flag bit only rises on a detected edge
  a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == '0) |=> ((flags & ~$past(flags)) == '0));

  // R9: a cleared bit without an edge drops
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && rise == '0) |=> ((flags & $past(clr_mask)) == '0));
endmodule

// File: rtl/wpr_regbank.sv
module wpr_regbank
  import wpr_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned NSTAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_src_dbg,
  input  logic             cpu_halted,
  input  logic [NLOCK-1:0] wp_lock,
  input  logic             standby,
  input  logic [NSTAT-1:0] stat_in,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_err,
  output logic             irq,
  output logic             wake
);
  logic             rst_meta, rst_s;
  logic [NLOCK-1:0] we_lk;
  logic             we_flg, blocked;
  logic [DW-1:0]    cfga, cfga_d, cfgb, cfgb_d;
  logic [NSTAT-1:0] ien, ien_d;
  logic [NSTAT-1:0] stat_q, flags;
  logic             irq_int;
  logic [DW-1:0]    rd_mux, rdata_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  wpr_guard #(.AW(AW)) u_guard (
    .wr      (bus_wr),
    .addr    (bus_addr),
    .lock    (wp_lock),
    .halted  (cpu_halted),
    .dbg     (bus_src_dbg),
    .we_lk   (we_lk),
    .we_flg  (we_flg),
    .blocked (blocked)
  );

  wpr_flags #(.N(NSTAT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_s),
    .stat_in  (stat_in),
    .clr_we   (we_flg),
    .clr_mask (bus_wdata[NSTAT-1:0]),
    .ien      (ien),
    .stat_q   (stat_q),
    .flags    (flags),
    .irq      (irq_int)
  );

  always_comb begin
    cfga_d = we_lk[ADR_CFGA] ? bus_wdata : cfga;
    cfgb_d = we_lk[ADR_CFGB] ? bus_wdata : cfgb;
    ien_d  = we_lk[ADR_IEN]  ? bus_wdata[NSTAT-1:0] : ien;
    case (bus_addr)
      AW'(ADR_CFGA): rd_mux = cfga;
      AW'(ADR_CFGB): rd_mux = cfgb;
      AW'(ADR_IEN):  rd_mux = DW'(ien);
      AW'(ADR_IFLG): rd_mux = DW'(flags);
      AW'(ADR_STAT): rd_mux = DW'(stat_q);
      default:       rd_mux = '0;
    endcase
    rdata_d = bus_rd ? rd_mux : bus_rdata;
    irq     = irq_int;
    wake    = irq_int & standby;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cfga      <= '0;
      cfgb      <= '0;
      ien       <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      cfga      <= cfga_d;
      cfgb      <= cfgb_d;
      ien       <= ien_d;
      bus_rdata <= rdata_d;
      bus_err   <= blocked;
    end
  end

  // R3: a locked CPU write keeps the word and answers with an error
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && bus_addr == AW'(ADR_CFGA) && wp_lock[ADR_CFGA] && !cpu_halted && !bus_src_dbg)
      |=> (bus_err && cfga == $past(cfga)));

  // R3: an error always follows a write
  a_r3_err_cause: assert property (@(posedge clk) disable iff (!rst_s)
    bus_err |-> $past(bus_wr));

  // R5: debug halt lifts every lock
  a_r5_halt_no_err: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && cpu_halted) |=> !bus_err);

  // R6: debugger-sourced writes pass
  a_r6_dbg_no_err: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && bus_src_dbg) |=> !bus_err);

  // R4: flag register writes never fault
  a_r4_flag_no_err: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && bus_addr == AW'(ADR_IFLG)) |=> !bus_err);

  // R11: wake only under standby with a pending interrupt
  a_r11_wake: assert property (@(posedge clk) disable iff (!rst_s)
    wake |-> (standby && irq));
endmodule

// File: tb/test_wpr_regbank.sv
module test_wpr_regbank;
  localparam int AW = 4, DW = 32, NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_src_dbg = 1'b0, cpu_halted = 1'b0, standby = 1'b0;
  logic [2:0] wp_lock = '0;
  logic [NS-1:0] stat_in = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_err, irq, wake;

  int total = 0, bad = 0;
  logic rd_d = 1'b0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  wpr_regbank #(.AW(AW), .DW(DW), .NSTAT(NS)) i_wpr_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_src_dbg(bus_src_dbg),
    .cpu_halted(cpu_halted), .wp_lock(wp_lock), .standby(standby),
    .stat_in(stat_in), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq(irq), .wake(wake)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capture
  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = AW'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=%0h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    check("R1 err", DW'(bus_err), 0);
    check("R1 irq", DW'(irq), 0);
    check("R1 rdata", bus_rdata, 0);
    rd(0, 0, "R1 cfga"); rd(2, 0, "R1 ien"); rd(3, 0, "R1 iflg"); rd(4, 0, "R1 stat");
    // R2 plain writes and readback
    wr(0, 32'hA5A5_0F0F); check("R2 no err", DW'(bus_err), 0);
    wr(1, 32'h1234_5678);
    wr(2, 32'hFFFF_FF0F);
    rd(0, 32'hA5A5_0F0F, "R2 cfga"); rd(1, 32'h1234_5678, "R2 cfgb"); rd(2, 32'h0F, "R2 ien");
    // R3 locked writes
    wp_lock = 3'b101;
    wr(0, 32'hDEAD_BEEF); check("R3 err pulse", DW'(bus_err), 1);
    tick(1); check("R3 err one cycle", DW'(bus_err), 0);
    wr(2, 32'h0); check("R3 ien err", DW'(bus_err), 1);
    wr(1, 32'h0000_00BB); check("R3 unlocked neighbour", DW'(bus_err), 0);
    rd(0, 32'hA5A5_0F0F, "R3 cfga kept"); rd(2, 32'h0F, "R3 ien kept"); rd(1, 32'hBB, "R3 cfgb");
    // R5 halted lifts lock
    cpu_halted = 1'b1;
    wr(0, 32'h0000_1111); check("R5 no err", DW'(bus_err), 0);
    cpu_halted = 1'b0;
    rd(0, 32'h1111, "R5 cfga");
    // R6 debugger bypass
    wp_lock = 3'b111; bus_src_dbg = 1'b1;
    wr(1, 32'h0000_2222); check("R6 no err", DW'(bus_err), 0);
    bus_src_dbg = 1'b0;
    rd(1, 32'h2222, "R6 cfgb");
    // R12 read-only and unmapped
    wr(4, 32'hFFFF_FFFF); check("R12 stat no err", DW'(bus_err), 0);
    wr(7, 32'hFFFF_FFFF); check("R12 unmapped no err", DW'(bus_err), 0);
    rd(4, 0, "R12 stat"); rd(7, 0, "R12 unmapped read"); rd(0, 32'h1111, "R12 cfga kept");
    rd(3, 0, "R12 iflg kept");
    // R7 status and R8 flag set
    stat_in = 8'h81;
    tick(3);
    rd(4, 32'h81, "R7 stat"); rd(3, 32'h81, "R8 flags set");
    check("R10 irq", DW'(irq), 1);
    check("R11 wake low", DW'(wake), 0);
    standby = 1'b1; #1;
    check("R11 wake high", DW'(wake), 1);
    // R4 flag clear under full lock
    wr(3, 32'h01); check("R4 no err", DW'(bus_err), 0);
    rd(3, 32'h80, "R4 cleared"); check("R10 irq off", DW'(irq), 0);
    check("R11 wake off", DW'(wake), 0);
    standby = 1'b0;
    // R8 held line does not re-set; R9 zero-write leaves bits
    wr(3, 32'h00); rd(3, 32'h80, "R9 zero write");
    wr(3, 32'h80); tick(3); rd(3, 0, "R8 no reset on level");
    // R9 set and clear in same cycle
    stat_in = 8'h83;
    tick(1);
    wr(3, 32'h02);
    rd(3, 32'h02, "R9 set wins");
    check("R10 irq again", DW'(irq), 1);
    wr(3, 32'h02); rd(3, 0, "R9 clear later");
    tick(2);
    check("R1 queue drained", DW'(exp_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule